// File: doc/BRIEF.md
# Half-Duplex Ethernet Transmit Retry Sequencer

This block decides when a half-duplex Ethernet transmitter may begin each attempt at sending a frame. It also decides what happens after a collision. A requester raises `frame_req_i` and holds it. The block waits until the line has been quiet for the interframe gap, then pulses `tx_start_o` so that the serializer begins sending.

During the first slot time of the attempt (the collision window), a collision report makes the block assert `jam_o` for the jam length. It then waits a random number of slot times, chosen by truncated binary exponential backoff, and tries again. An attempt that passes the whole collision window without a collision ends with a `done_o` pulse. A frame that collides on every one of its allowed attempts ends with a `retry_err_o` pulse.

All timing is counted in bit times, each marked by one `bit_tick_i` pulse, so the same logic serves any line rate up to 10 Mbps. `mode_i` selects the standard backoff or one of the gentler variants. The gentler variants add a slot to every wait, shrink the exponent cap, or do both.

Top module: `csma_retry_ctrl`

## Requirements
- R1: After reset, every output (`tx_start_o`, `jam_o`, `done_o`, `retry_err_o`) is low and no attempt is in progress.
- R2: `tx_start_o` is a one-cycle pulse that is issued only from the idle state. It requires `frame_req_i` high, `crs_i` low, and at least IFG_BITS ticks since reset, since the last cycle with `crs_i` high, and since the last cycle of own transmission or jam.
- R3: Any cycle with `crs_i` high restarts the interframe gap count from zero.
- R4: A collision in any cycle of an attempt starts the jam in the next cycle. `jam_o` then stays high for exactly JAM_BITS ticks, and `col_i` is ignored during the jam.
- R5: An attempt that reaches SLOT_BITS ticks without a collision ends with a one-cycle `done_o` pulse and clears the collision count. A collision in the same cycle as the final window tick wins, and a jam follows instead of `done_o`.
- R6: After the jam of collision number n (n ≥ 1) for a frame, the block waits r×SLOT_BITS ticks, then applies the gap rule of R2 before the next attempt. In standard mode, r = lfsr[9:0] AND (2^min(n,10) − 1), sampled in the cycle the jam ends.
- R7: The random source is a 16-bit left-shifting register. It is loaded with 0xACE1 at reset and advances on every clock. The new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R8: `mode_i` encodes the backoff variant. Bit 0 set adds one slot to r. Bit 1 set lowers the exponent cap from 10 to 4. So 0 is standard, 1 adds a slot, 2 uses the lower cap, and 3 does both.
- R9: If the 16th collision of one frame occurs, then at the end of its jam the block pulses `retry_err_o` for one cycle instead of backing off. It returns to idle with the collision count cleared, after exactly 16 `tx_start_o` pulses for that frame.
- R10: `frame_req_i` is sampled only in the idle state, and `col_i` has no effect outside an attempt. Dropping the request mid-attempt does not stop that attempt, and a collision while idle starts no jam.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_req_i | input | 1 | A frame is waiting to be sent |
| col_i | input | 1 | Collision reported by the line interface |
| crs_i | input | 1 | Carrier sensed on the line |
| bit_tick_i | input | 1 | One pulse per bit time |
| mode_i | input | 2 | Backoff variant select |
| tx_start_o | output | 1 | Pulse: begin serializing the frame |
| jam_o | output | 1 | Drive the jam pattern |
| done_o | output | 1 | Pulse: frame sent without collision |
| retry_err_o | output | 1 | Pulse: retry limit reached, frame abandoned |

## Verification
The hazardous coincidence is a collision arriving in the very cycle that carries the last tick of the collision window. In that cycle, the end of the window and the start of a jam compete. The bench provokes this by asserting `col_i` exactly SLOT_BITS−1 cycles after the observed `tx_start_o`, with a tick on every cycle. A behavioural model, built from countdowns and its own copy of the random sequence, expects a jam followed by a retry and no `done_o`. A second coincidence, the end of the 16th jam, must yield `retry_err_o` and no backoff; the bench checks this against the model and by counting start pulses.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TX      = 2'd1,
    ST_JAM     = 2'd2,
    ST_BACKOFF = 2'd3
  } csma_state_e;

  // mode bit 0: one extra slot; mode bit 1: reduced exponent cap
  localparam int unsigned MODE_EXTRA_BIT = 0;
  localparam int unsigned MODE_CAP_BIT   = 1;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int unsigned W     = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter int unsigned OUT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};
  end

  assign rnd_o = lfsr_q[OUT_W-1:0];

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R7
endmodule

// File: rtl/csma_tick_cnt.sv
module csma_tick_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/csma_backoff_calc.sv
module csma_backoff_calc #(
  parameter int unsigned EXP_CAP    = 10,
  parameter int unsigned NA_EXP_CAP = 4,
  parameter int unsigned ATT_W      = 5,
  localparam int unsigned RND_W     = EXP_CAP,
  localparam int unsigned OUT_W     = EXP_CAP + 1
) (
  input  logic [RND_W-1:0] rnd_i,
  input  logic [ATT_W-1:0] n_i,
  input  logic [1:0]       mode_i,
  output logic [OUT_W-1:0] slots_o
);
  import csma_pkg::*;

  localparam logic [RND_W:0] ONE = 1;

  int unsigned lim, e;
  logic [RND_W:0]   full;
  logic [RND_W-1:0] mask;

  always_comb begin
    lim  = mode_i[MODE_CAP_BIT] ? NA_EXP_CAP : EXP_CAP;
    e    = (int'(n_i) < lim) ? int'(n_i) : lim;
    full = (ONE << e) - ONE;
    mask = full[RND_W-1:0];
    slots_o = {1'b0, rnd_i & mask} + OUT_W'(mode_i[MODE_EXTRA_BIT]);
  end
endmodule

// File: rtl/csma_retry_ctrl.sv
module csma_retry_ctrl #(
  parameter int unsigned IFG_BITS     = 96,
  parameter int unsigned JAM_BITS     = 32,
  parameter int unsigned SLOT_BITS    = 512,
  parameter int unsigned MAX_ATTEMPTS = 16,
  parameter int unsigned EXP_CAP      = 10,
  parameter int unsigned NA_EXP_CAP   = 4,
  parameter int unsigned LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_req_i,
  input  logic       col_i,
  input  logic       crs_i,
  input  logic       bit_tick_i,
  input  logic [1:0] mode_i,
  output logic       tx_start_o,
  output logic       jam_o,
  output logic       done_o,
  output logic       retry_err_o
);
  import csma_pkg::*;

  localparam int unsigned PH_MAX  = (SLOT_BITS > JAM_BITS) ? SLOT_BITS : JAM_BITS;
  localparam int unsigned PH_W    = $clog2(PH_MAX);
  localparam int unsigned GAP_W   = $clog2(IFG_BITS + 1);
  localparam int unsigned ATT_W   = $clog2(MAX_ATTEMPTS + 1);
  localparam int unsigned SLOTS_W = EXP_CAP + 1;

  localparam logic [PH_W-1:0]  SLOT_LAST = PH_W'(SLOT_BITS - 1);
  localparam logic [PH_W-1:0]  JAM_LAST  = PH_W'(JAM_BITS - 1);
  localparam logic [GAP_W-1:0] GAP_FULL  = GAP_W'(IFG_BITS);
  localparam logic [ATT_W-1:0] COL_LAST  = ATT_W'(MAX_ATTEMPTS - 1);

  csma_state_e state_q, state_d;
  logic [PH_W-1:0]    ph_cnt;
  logic [GAP_W-1:0]   gap_cnt;
  logic [ATT_W-1:0]   col_cnt_q;
  logic [SLOTS_W-1:0] slots_q, slots_calc;
  logic [EXP_CAP-1:0] rnd;
  logic gap_ok, slot_wrap;
  logic start_d, done_d, err_d, ld_slots, col_inc, col_clr;
  logic start_q, done_q, err_q;

  // interframe gap: restarts on carrier or own activity, saturates when met
  assign gap_ok = (gap_cnt == GAP_FULL);

  csma_tick_cnt #(.W(GAP_W)) u_gap_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (crs_i || state_q == ST_TX || state_q == ST_JAM),
    .en_i  (bit_tick_i && !gap_ok),
    .cnt_o (gap_cnt)
  );

  // phase counter: collision window, jam length, bits within a backoff slot
  assign slot_wrap = (state_q == ST_BACKOFF) && bit_tick_i && (ph_cnt == SLOT_LAST);

  csma_tick_cnt #(.W(PH_W)) u_ph_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i ((state_d != state_q) || slot_wrap),
    .en_i  (bit_tick_i && state_q != ST_IDLE),
    .cnt_o (ph_cnt)
  );

  csma_lfsr #(
    .W    (LFSR_W),
    .SEED (LFSR_SEED),
    .OUT_W(EXP_CAP)
  ) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rnd_o (rnd)
  );

  csma_backoff_calc #(
    .EXP_CAP   (EXP_CAP),
    .NA_EXP_CAP(NA_EXP_CAP),
    .ATT_W     (ATT_W)
  ) u_backoff_calc (
    .rnd_i  (rnd),
    .n_i    (col_cnt_q + 1'b1),
    .mode_i (mode_i),
    .slots_o(slots_calc)
  );

  always_comb begin
    state_d  = state_q;
    start_d  = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    ld_slots = 1'b0;
    col_inc  = 1'b0;
    col_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_req_i && !crs_i && gap_ok) begin
          state_d = ST_TX;
          start_d = 1'b1;
        end
      end
      ST_TX: begin
        if (col_i) begin
          state_d = ST_JAM;
        end else if (bit_tick_i && ph_cnt == SLOT_LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          col_clr = 1'b1;
        end
      end
      ST_JAM: begin
        if (bit_tick_i && ph_cnt == JAM_LAST) begin
          if (col_cnt_q == COL_LAST) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
            col_clr = 1'b1;
          end else begin
            state_d  = ST_BACKOFF;
            ld_slots = 1'b1;
            col_inc  = 1'b1;
          end
        end
      end
      ST_BACKOFF: begin
        if (slots_q == '0) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      col_cnt_q <= '0;
      slots_q   <= '0;
      start_q   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (col_clr)      col_cnt_q <= '0;
      else if (col_inc) col_cnt_q <= col_cnt_q + 1'b1;
      if (ld_slots)                        slots_q <= slots_calc;
      else if (slot_wrap && slots_q != '0) slots_q <= slots_q - 1'b1;
    end
  end

  assign tx_start_o  = start_q;
  assign jam_o       = (state_q == ST_JAM);
  assign done_o      = done_q;
  assign retry_err_o = err_q;

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o); // R2
  AST_START_QUIET_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(!crs_i && frame_req_i)); // R2
  AST_COL_TO_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX && col_i) |=> jam_o); // R4
  AST_JAM_ENDS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jam_o && !bit_tick_i) |=> jam_o); // R4
  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && retry_err_o)); // R5
  AST_DONE_NOT_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !jam_o && !$past(jam_o)); // R5
  AST_BACKOFF_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BACKOFF) |=> !tx_start_o); // R6
  AST_ERR_AFTER_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_err_o |-> $past(jam_o)); // R9
  AST_COL_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_cnt_q < ATT_W'(MAX_ATTEMPTS)); // R9
  AST_IDLE_COL_NO_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> !jam_o); // R10
endmodule

// File: tb/csma_retry_ctrl_tb.sv
`timescale 1ns/1ps
module csma_retry_ctrl_tb;
  localparam int IFG  = 6;
  localparam int JAM  = 4;
  localparam int SLOT = 8;
  localparam int MAXA = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, col = 1'b0, crs = 1'b0, tick = 1'b0;
  logic [1:0] mode = 2'd0;
  logic tx_start, jam, done, err;

  int checks = 0, fails = 0, cyc = 0, tick_div = 1, starts = 0;
  string ctx = "R1";
  bit ending = 1'b0;

  always #2.5 clk = ~clk;

  csma_retry_ctrl #(
    .IFG_BITS(IFG), .JAM_BITS(JAM), .SLOT_BITS(SLOT), .MAX_ATTEMPTS(MAXA)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_req_i(req), .col_i(col), .crs_i(crs),
    .bit_tick_i(tick), .mode_i(mode), .tx_start_o(tx_start), .jam_o(jam),
    .done_o(done), .retry_err_o(err)
  );

  // behavioural reference: remaining-time countdowns
  int m_st, m_gap, m_tx, m_jam, m_bo, m_cols;
  bit m_start, m_done, m_err;
  logic [15:0] m_lf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_gap = IFG; m_tx = 0; m_jam = 0; m_bo = 0; m_cols = 0;
      m_start = 0; m_done = 0; m_err = 0; m_lf = 16'hACE1;
    end else begin
      int st, gap_old, e, r;
      st = m_st; gap_old = m_gap;
      if (crs || st == 1 || st == 2) m_gap = IFG;
      else if (tick && m_gap > 0) m_gap--;
      m_start = 0; m_done = 0; m_err = 0;
      case (st)
        0: if (req && !crs && gap_old == 0) begin m_st = 1; m_tx = SLOT; m_start = 1; end
        1: if (col) begin m_st = 2; m_jam = JAM; end
           else if (tick) begin
             m_tx--;
             if (m_tx == 0) begin m_done = 1; m_st = 0; m_cols = 0; end
           end
        2: if (tick) begin
             m_jam--;
             if (m_jam == 0) begin
               m_cols++;
               if (m_cols == MAXA) begin m_err = 1; m_st = 0; m_cols = 0; end
               else begin
                 e = (m_cols < (mode[1] ? 4 : 10)) ? m_cols : (mode[1] ? 4 : 10);
                 r = int'(m_lf[9:0]) & ((1 << e) - 1);
                 if (mode[0]) r++;
                 m_bo = r * SLOT; m_st = 3;
               end
             end
           end
        default: if (m_bo == 0) m_st = 0; else if (tick) m_bo--;
      endcase
      m_lf = {m_lf[14:0], m_lf[15] ^ m_lf[13] ^ m_lf[12] ^ m_lf[10]};
    end
  end

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", rq, ctx, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    ending = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // per-cycle comparison, tick generation, watchdog
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !ending) begin
      chk("R2", int'(tx_start), int'(m_start));
      chk("R4", int'(jam), int'(m_st == 2));
      chk("R5", int'(done), int'(m_done));
      chk("R9", int'(err), int'(m_err));
      if (tx_start) starts++;
    end
    tick = ((cyc % tick_div) == 0);
    if (cyc > 150000 && !ending) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  task automatic run_frame(int n_col, int delay, int hold, output bit got_err);
    int c = 0;
    req = 1'b1; got_err = 1'b0;
    forever begin
      @(negedge clk);
      if (done || err) begin got_err = err; break; end
      if (tx_start && c < n_col) begin
        repeat (delay) @(negedge clk);
        col = 1'b1;
        repeat (hold) @(negedge clk);
        col = 1'b0;
        c++;
      end
    end
    req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bit e;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(tx_start), 0); chk("R1", int'(jam), 0);
    chk("R1", int'(done), 0);     chk("R1", int'(err), 0);

    ctx = "R2"; run_frame(0, 0, 1, e); chk("R2", int'(e), 0);

    ctx = "R3"; req = 1'b1; s0 = starts;
    for (int i = 0; i < 4; i++) begin
      crs = 1'b1; repeat (2) @(negedge clk);
      crs = 1'b0; repeat (IFG - 2) @(negedge clk);
    end
    chk("R3", starts - s0, 0);
    run_frame(0, 0, 1, e); chk("R3", int'(e), 0);

    ctx = "R4"; run_frame(3, 2, 3, e); chk("R4", int'(e), 0);
    ctx = "R5"; run_frame(1, SLOT - 1, 1, e); chk("R5", int'(e), 0);
    ctx = "R6"; run_frame(6, 1, 1, e); chk("R6", int'(e), 0);
    ctx = "R7"; run_frame(4, 3, 1, e); run_frame(5, 0, 2, e); chk("R7", int'(e), 0);

    ctx = "R8";
    mode = 2'd1; run_frame(3, 1, 1, e);
    mode = 2'd2; run_frame(7, 2, 1, e);
    mode = 2'd3; run_frame(3, 0, 1, e); chk("R8", int'(e), 0);

    ctx = "R9"; s0 = starts;
    run_frame(99, 1, 1, e);
    chk("R9", int'(e), 1); chk("R9", starts - s0, MAXA);

    ctx = "R10"; mode = 2'd0; req = 1'b1;
    while (!tx_start) @(negedge clk);
    repeat (2) @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    chk("R10", int'(done), 1);
    s0 = starts;
    for (int i = 0; i < 5; i++) begin
      col = 1'b1; @(negedge clk); col = 1'b0; repeat (3) @(negedge clk);
    end
    chk("R10", starts - s0, 0); chk("R10", int'(jam), 0);

    ctx = "R2"; tick_div = 3; run_frame(2, 4, 1, e); chk("R2", int'(e), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule